// File: doc/BRIEF.md
# Line-Scan Sensor Timing Controller

This block derives every timing signal a cascaded contact image sensor line array needs from a fast system clock. It produces the sensor clock, the per-line start pulse and the flush-control strobe. It also gives a downstream video sampler a pixel-valid level and a pixel index, so the sampler knows which analog sample belongs to which photo-site.

Software-independent settings arrive on two buses. The first sets the sensor clock half period in system clocks. The second sets the line period, which is the integration time, in sensor clock cycles. The block raises both settings to their safe minimums, and it reads them only when a new line begins. Each sensor clock cycle carries two pixels, one in its low half and one in its high half. The first 55 sensor clock cycles of a line are preprocessing, and no video comes out during them. A flush request turns the next line into a flush line: the flush strobe opens a short window early in that line, and no pixels are marked valid.

Top module: `cis_line_timer`

## Requirements
- R1: `cp` spends exactly H system clocks low, then exactly H system clocks high, in every cycle, where H = max(`half_div`, MIN_HALF). This gives a 50% duty cycle.
- R2: `sp` is high for exactly one whole `cp` cycle, cycle 0 of each line. It rises at the start of the line and falls together with the first falling edge of `cp`.
- R3: The time between two line starts is P `cp` cycles, where P = max(`line_len`, 1260).
- R4: `half_div` and `line_len` are sampled only on the clock edge that begins a line. A change in the middle of a line first affects the following line.
- R5: Outside a flush line, `pix_valid` is high during `cp` cycles 55 through 1258 of a line, counting the start pulse cycle as 0. `pix_idx` is 0 in the low half of cycle 55 and rises by one every half cycle, up to 2407. It is 0 whenever `pix_valid` is low.
- R6: A `flush_req` pulse is held until the next line start, which makes that line a flush line. In a flush line, `sic` is high during `cp` cycles 53 to 56 only, and `pix_valid` stays low for the whole line. A request that arrives on the very edge that starts a line applies to that line.
- R7: `line_start` is a one-system-clock pulse in the first system clock of every line.
- R8: While `rst_n` is low, all outputs are 0. The first line begins on the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_div | input | DIV_W | Sensor clock half period in system clocks |
| line_len | input | LINE_W | Line period in sensor clock cycles |
| flush_req | input | 1 | Request that the next line be a flush line |
| cp | output | 1 | Sensor clock |
| sp | output | 1 | Line start pulse to the sensor |
| sic | output | 1 | Flush-control strobe |
| pix_valid | output | 1 | High while a valid video pixel is being presented |
| pix_idx | output | IDX_W | Index of the current pixel within the line |
| line_start | output | 1 | One-clock marker at the start of each line |

## Verification
If the phase counter or the half-period state is off by one, the duty cycle or the place where `cp` changes shifts. This shows up at the ports within one sensor clock half period. If the cycle counter or the latched period is wrong, the video window and the pixel index are displaced within the same line, and the next start pulse arrives early or late. A lost or early flush request leaves `sic` and `pix_valid` wrong across a whole line. For this reason the bench compares every output on every clock against a model built on elapsed time, and it also measures the spacing of line starts.

// File: rtl/cis_line_timer.sv
module cis_line_timer #(
  parameter int DIV_W    = 8,
  parameter int LINE_W   = 16,
  parameter int PIXELS   = 2408,
  parameter int PREP     = 55,
  parameter int MIN_HALF = 25,
  parameter int FLUSH_LO = 53,
  parameter int FLUSH_HI = 56,
  localparam int CP_PIX   = PIXELS / 2,
  localparam int MIN_LINE = PREP + 1 + CP_PIX,
  localparam int IDX_W    = $clog2(PIXELS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  half_div,
  input  logic [LINE_W-1:0] line_len,
  input  logic              flush_req,
  output logic              cp,
  output logic              sp,
  output logic              sic,
  output logic              pix_valid,
  output logic [IDX_W-1:0]  pix_idx,
  output logic              line_start
);

  logic              run, hi, flush_line, pend;
  logic [DIV_W-1:0]  ph, hq;
  logic [LINE_W-1:0] cyc, per_q, voff;

  wire tick = ph == hq - DIV_W'(1);
  wire last = cyc == per_q - LINE_W'(1);
  wire wrap = !run || (tick && hi && last);
  wire [DIV_W-1:0]  hq_next  = (half_div < DIV_W'(MIN_HALF)) ? DIV_W'(MIN_HALF) : half_div;
  wire [LINE_W-1:0] per_next = (line_len < LINE_W'(MIN_LINE)) ? LINE_W'(MIN_LINE) : line_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run        <= 1'b0;
      hi         <= 1'b0;
      ph         <= '0;
      cyc        <= '0;
      hq         <= DIV_W'(MIN_HALF);
      per_q      <= LINE_W'(MIN_LINE);
      flush_line <= 1'b0;
      pend       <= 1'b0;
    end else begin
      run  <= 1'b1;
      pend <= wrap ? 1'b0 : (pend | flush_req);
      if (wrap) begin
        ph         <= '0;
        hi         <= 1'b0;
        cyc        <= '0;
        hq         <= hq_next;
        per_q      <= per_next;
        flush_line <= pend | flush_req;
      end else if (tick) begin
        ph <= '0;
        hi <= ~hi;
        if (hi) cyc <= cyc + LINE_W'(1);
      end else begin
        ph <= ph + DIV_W'(1);
      end
    end
  end

  wire in_vid = cyc >= LINE_W'(PREP) && cyc < LINE_W'(PREP + CP_PIX);
  assign voff       = cyc - LINE_W'(PREP);
  assign cp         = run & hi;
  assign sp         = run & (cyc == '0);
  assign line_start = run & (cyc == '0) & !hi & (ph == '0);
  assign sic        = run & flush_line & (cyc >= LINE_W'(FLUSH_LO)) & (cyc <= LINE_W'(FLUSH_HI));
  assign pix_valid  = run & !flush_line & in_vid;
  assign pix_idx    = pix_valid ? IDX_W'({voff, hi}) : '0;

  logic              chk_cp_d;
  logic [LINE_W:0]   chk_gap;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_cp_d <= 1'b0;
      chk_gap  <= '0;
    end else begin
      chk_cp_d <= cp;
      if (line_start)         chk_gap <= '0;
      else if (cp && !chk_cp_d) chk_gap <= chk_gap + 1'b1;
    end
  end

  AST_SP_FALLS_WITH_CP: assert property (@(posedge clk) disable iff (!rst_n) $fell(sp) |-> $fell(cp)); // R2
  AST_LINE_SPACING: assert property (@(posedge clk) disable iff (!rst_n) line_start |-> (chk_gap == '0 || chk_gap >= (LINE_W+1)'(MIN_LINE))); // R3
  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n) pix_valid |-> pix_idx < IDX_W'(PIXELS)); // R5
  AST_FLUSH_NO_VIDEO: assert property (@(posedge clk) disable iff (!rst_n) sic |-> !pix_valid); // R6
  AST_START_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n) line_start |=> !line_start); // R7

endmodule

// File: tb/cis_line_timer_test.sv
module cis_line_timer_test;
  localparam int MINH = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  half_div = 8'd2;
  logic [15:0] line_len = 16'd0;
  logic        flush_req = 1'b0;
  logic        cp, sp, sic, pix_valid, line_start;
  logic [11:0] pix_idx;

  always #4 clk = ~clk;

  cis_line_timer #(.MIN_HALF(MINH)) uut (
    .clk(clk), .rst_n(rst_n), .half_div(half_div), .line_len(line_len),
    .flush_req(flush_req), .cp(cp), .sp(sp), .sic(sic), .pix_valid(pix_valid),
    .pix_idx(pix_idx), .line_start(line_start)
  );

  int checks = 0;
  int errors = 0;
  int t = 0, m_hq = MINH, m_per = 1260, ended_len = 0;
  int since_ls = 0, n_clk = 0;
  bit m_run = 0, m_fl = 0, m_pend = 0, armed = 0, seen_ls = 0, m_rst = 1;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at time %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    armed = 1;
    m_rst = !rst_n;
    if (!rst_n) begin
      m_run = 0; m_pend = 0; m_fl = 0; t = 0;
    end else if (!m_run || t == m_per * 2 * m_hq - 1) begin
      ended_len = m_run ? m_per * 2 * m_hq : 0;
      m_run = 1;
      t = 0;
      m_hq  = (int'(half_div) < MINH) ? MINH : int'(half_div);
      m_per = (int'(line_len) < 1260) ? 1260 : int'(line_len);
      m_fl  = m_pend | flush_req;
      m_pend = 0;
    end else begin
      t++;
      if (flush_req) m_pend = 1;
    end
  end

  always @(negedge clk) begin
    n_clk++;
    if (armed) begin
      if (m_rst || !m_run) begin
        chk("R8 cp", int'(cp), 0);
        chk("R8 sp", int'(sp), 0);
        chk("R8 sic", int'(sic), 0);
        chk("R8 pix_valid", int'(pix_valid), 0);
        chk("R8 line_start", int'(line_start), 0);
      end else begin
        int c, h, pv, idx;
        c  = t / (2 * m_hq);
        h  = ((t % (2 * m_hq)) >= m_hq) ? 1 : 0;
        pv = (!m_fl && c >= 55 && c <= 1258) ? 1 : 0;
        idx = pv ? 2 * (c - 55) + h : 0;
        chk("R1 cp", int'(cp), h);
        chk("R2 sp", int'(sp), (c == 0) ? 1 : 0);
        chk("R7 line_start", int'(line_start), (t == 0) ? 1 : 0);
        chk(m_fl ? "R6 pix_valid" : "R5 pix_valid", int'(pix_valid), pv);
        chk("R5 pix_idx", int'(pix_idx), idx);
        chk("R6 sic", int'(sic), (m_fl && c >= 53 && c <= 56) ? 1 : 0);
        since_ls++;
        if (t == 0) begin
          if (seen_ls) chk("R3 R4 line spacing", since_ls, ended_len);
          seen_ls = 1;
          since_ls = 0;
        end
      end
    end
    if (n_clk > 150000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected 0", n_clk);
      finish_run();
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2000) @(negedge clk);
    line_len = 16'd1300;
    half_div = 8'd3;
    repeat (6000) @(negedge clk);
    flush_req = 1'b1;
    @(negedge clk);
    flush_req = 1'b0;
    repeat (2000) @(negedge clk);
    line_len = 16'd1500;
    half_div = 8'd0;
    repeat (10000) @(negedge clk);
    flush_req = 1'b1;
    repeat (3) @(negedge clk);
    flush_req = 1'b0;
    repeat (4000) @(negedge clk);
    line_len = 16'd100;
    half_div = 8'd1;
    repeat (20000) @(negedge clk);
    finish_run();
  end
endmodule